// File: doc/BRIEF.md
# Sub-Dword Operand Select Unit

This unit sits around a 32-bit integer operation. It conditions the two source operands on the way in and the destination word on the way out. For each source it extracts a byte, a half-word or the whole word, then zero- or sign-extends that piece to 32 bits. The two extended operands go to the operation, which is outside the unit.

The result of the operation comes back to the unit, and its low bits are written into a chosen field of the destination word. One of three fill rules decides the destination bits outside that field: they are cleared, they take the sign of the field, or they keep the previous destination value. The merged word is registered and marked valid for one cycle.

The output stage is a two-state machine. In `ST_IDLE` the output holds no new item. In `ST_VALID` `dest_out` carries the item accepted on the previous edge. The state goes to `ST_VALID` on any edge that sees `in_valid`, and returns to `ST_IDLE` on any edge where `in_valid` is low.

Top module: `subdword_sel_unit`

## Requirements
- R1: Pick codes are 3 bits wide. Codes 0, 1, 2 and 3 select bits [7:0], [15:8], [23:16] and [31:24]. Codes 4 and 5 select bits [15:0] and [31:16]. Code 6 selects the whole word, and code 7 also selects the whole word. When the signed flag is low, the picked field is returned right-aligned with zeros above it.
- R2: When the signed flag is high and a byte or half-word is picked, every bit above the field equals the field's top bit.
- R3: When code 6 or 7 is picked, the operand equals the source word unchanged, whatever the signed flag.
- R4: The second source has its own pick code and signed flag and follows R1 to R3 independently of the first source, in the same cycle.
- R5: The low bits of `res_in`, as many as the width of the field that `wr_pick` selects (same encoding as R1), are written at that field's bit position in `dest_out`.
- R6: With fill mode 0 (zero), every destination bit outside the field is 0.
- R7: With fill mode 1 (sign), destination bits above the field copy the field's top bit, and bits below the field are 0.
- R8: With fill mode 2 or 3 (keep), destination bits outside the field take the value of `dest_prev` from the accepted cycle.
- R9: `dest_vld` is high in exactly the cycle after an edge that saw `in_valid` high, and low after an edge that saw it low.
- R10: When `in_valid` is low, `dest_out` keeps its value.
- R11: While `rst_n` is low, `dest_vld` and `dest_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the current merge inputs on this edge |
| a_in | input | 32 | First source word |
| b_in | input | 32 | Second source word |
| a_pick | input | 3 | Field code for the first source |
| b_pick | input | 3 | Field code for the second source |
| a_signed | input | 1 | Sign-extend the first source field |
| b_signed | input | 1 | Sign-extend the second source field |
| wr_pick | input | 3 | Destination field code |
| fill_mode | input | 2 | Rule for destination bits outside the field |
| dest_prev | input | 32 | Previous destination value |
| res_in | input | 32 | Result from the operation |
| a_ext | output | 32 | Extended first operand (combinational) |
| b_ext | output | 32 | Extended second operand (combinational) |
| dest_out | output | 32 | Registered merged destination |
| dest_vld | output | 1 | `dest_out` carries a new item |

## Verification
Two functions are active in the same cycle. One is the combinational extraction of a new item's operands. The other is the registered merge output of the item accepted one edge earlier. The bench streams every combination of source code, destination code and fill mode back-to-back, so these two always overlap. Operands are compared in the cycle they are driven, and merged words are compared by the scoreboard one cycle later.

// File: rtl/sdsel_pkg.sv
package sdsel_pkg;
    localparam int WORD_W = 32;
    localparam int PICK_W = 3;
    localparam int FILL_W = 2;
    localparam int LSB_W  = $clog2(WORD_W);

    typedef enum logic [PICK_W-1:0] {
        PK_B0       = 3'd0,
        PK_B1       = 3'd1,
        PK_B2       = 3'd2,
        PK_B3       = 3'd3,
        PK_H0       = 3'd4,
        PK_H1       = 3'd5,
        PK_FULL     = 3'd6,
        PK_FULL_ALT = 3'd7
    } pick_t;

    typedef enum logic [FILL_W-1:0] {
        FL_ZERO     = 2'd0,
        FL_SIGN     = 2'd1,
        FL_KEEP     = 2'd2,
        FL_KEEP_ALT = 2'd3
    } fill_t;

    // bit position of the field's least significant bit
    function automatic logic [LSB_W-1:0] pick_lsb(pick_t p);
        logic [LSB_W-1:0] r;
        unique case (p)
            PK_B1:   r = LSB_W'(8);
            PK_B2:   r = LSB_W'(16);
            PK_B3:   r = LSB_W'(24);
            PK_H1:   r = LSB_W'(16);
            default: r = '0;
        endcase
        return r;
    endfunction

    // right-aligned mask covering the field width
    function automatic logic [WORD_W-1:0] pick_mask(pick_t p);
        logic [WORD_W-1:0] r;
        unique case (p)
            PK_B0, PK_B1, PK_B2, PK_B3: r = {{(WORD_W-8){1'b0}}, 8'hFF};
            PK_H0, PK_H1:               r = {{(WORD_W-16){1'b0}}, 16'hFFFF};
            default:                    r = '1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sdsel_extract.sv
module sdsel_extract
    import sdsel_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] word,
    input  pick_t        pick,
    input  logic         sext,
    output logic [W-1:0] ext
);
    logic [W-1:0] mask;
    logic [W-1:0] aligned;
    logic         top_bit;

    always_comb begin
        mask    = W'(pick_mask(pick));
        aligned = (word >> pick_lsb(pick)) & mask;
        // mask ^ (mask >> 1) isolates the field's top bit position
        top_bit = |(aligned & (mask ^ (mask >> 1)));
        ext     = aligned | ((sext && top_bit) ? ~mask : '0);
    end
endmodule

// File: rtl/sdsel_merge.sv
module sdsel_merge
    import sdsel_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] res,
    input  logic [W-1:0] prev,
    input  pick_t        pick,
    input  fill_t        fill,
    output logic [W-1:0] merged
);
    logic [W-1:0] mask;
    logic [W-1:0] field_m;
    logic [W-1:0] below_m;
    logic [W-1:0] above_m;
    logic [W-1:0] placed;
    logic         sbit;

    always_comb begin
        mask    = W'(pick_mask(pick));
        field_m = mask << pick_lsb(pick);
        below_m = ~({W{1'b1}} << pick_lsb(pick));
        above_m = ~(field_m | below_m);
        placed  = (res << pick_lsb(pick)) & field_m;
        sbit    = |(res & (mask ^ (mask >> 1)));
        unique case (fill)
            FL_ZERO: merged = placed;
            FL_SIGN: merged = placed | (sbit ? above_m : '0);
            default: merged = placed | (prev & ~field_m);
        endcase
    end
endmodule

// File: rtl/subdword_sel_unit.sv
module subdword_sel_unit
    import sdsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   a_in,
    input  logic [WORD_W-1:0]   b_in,
    input  logic [PICK_W-1:0]   a_pick,
    input  logic [PICK_W-1:0]   b_pick,
    input  logic                a_signed,
    input  logic                b_signed,
    input  logic [PICK_W-1:0]   wr_pick,
    input  logic [FILL_W-1:0]   fill_mode,
    input  logic [WORD_W-1:0]   dest_prev,
    input  logic [WORD_W-1:0]   res_in,
    output logic [WORD_W-1:0]   a_ext,
    output logic [WORD_W-1:0]   b_ext,
    output logic [WORD_W-1:0]   dest_out,
    output logic                dest_vld
);
    localparam int N_SRC = 2;

    typedef enum logic {ST_IDLE = 1'b0, ST_VALID = 1'b1} out_state_t;

    out_state_t  state_q, state_d;
    logic [WORD_W-1:0] src_w  [N_SRC];
    logic [PICK_W-1:0] pick_w [N_SRC];
    logic              sx_w   [N_SRC];
    logic [WORD_W-1:0] ext_w  [N_SRC];
    logic [WORD_W-1:0] merged;

    assign src_w[0]  = a_in;
    assign src_w[1]  = b_in;
    assign pick_w[0] = a_pick;
    assign pick_w[1] = b_pick;
    assign sx_w[0]   = a_signed;
    assign sx_w[1]   = b_signed;

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
        sdsel_extract #(.W(WORD_W)) u_x (
            .word (src_w[gi]),
            .pick (pick_t'(pick_w[gi])),
            .sext (sx_w[gi]),
            .ext  (ext_w[gi])
        );
    end

    assign a_ext = ext_w[0];
    assign b_ext = ext_w[1];

    sdsel_merge #(.W(WORD_W)) u_merge (
        .res    (res_in),
        .prev   (dest_prev),
        .pick   (pick_t'(wr_pick)),
        .fill   (fill_t'(fill_mode)),
        .merged (merged)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        dest_out <= '0;
        else if (in_valid) dest_out <= merged;
    end

    assign dest_vld = (state_q == ST_VALID);
endmodule

// File: rtl/sdsel_checks.sv
module sdsel_checks
    import sdsel_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [WORD_W-1:0]   a_in,
    input logic [PICK_W-1:0]   a_pick,
    input logic                a_signed,
    input logic [WORD_W-1:0]   a_ext,
    input logic [PICK_W-1:0]   wr_pick,
    input logic [FILL_W-1:0]   fill_mode,
    input logic [WORD_W-1:0]   dest_prev,
    input logic [WORD_W-1:0]   dest_out,
    input logic                dest_vld
);
    a_r1_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (a_pick < 3'd4 && !a_signed) |-> (a_ext[31:8] == 24'd0));

    a_r2_byte_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (a_pick < 3'd4 && a_signed) |-> (a_ext[31:8] == {24{a_ext[7]}}));

    a_r3_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (a_pick >= 3'd6) |-> (a_ext == a_in));

    a_r6_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fill_mode == 2'd0 && wr_pick == 3'd1)
        |=> (dest_out[7:0] == 8'd0 && dest_out[31:16] == 16'd0));

    a_r8_keep_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fill_mode[1] && wr_pick == 3'd5)
        |=> (dest_out[15:0] == $past(dest_prev[15:0])));

    a_r9_vld_set: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dest_vld);

    a_r9_vld_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dest_vld);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dest_out));
endmodule

bind subdword_sel_unit sdsel_checks u_chk (.*);

// File: tb/subdword_sel_unit_tb_top.sv
module subdword_sel_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] a_in = '0, b_in = '0, dest_prev = '0, res_in = '0;
    logic [2:0]  a_pick = '0, b_pick = '0, wr_pick = '0;
    logic        a_signed = 1'b0, b_signed = 1'b0;
    logic [1:0]  fill_mode = '0;
    logic [31:0] a_ext, b_ext, dest_out;
    logic        dest_vld;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_exp = '0;

    always #10 clk = ~clk;

    subdword_sel_unit dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void field_of(logic [2:0] p, output int lo, output int w);
        case (p)
            3'd0: begin lo = 0;  w = 8;  end
            3'd1: begin lo = 8;  w = 8;  end
            3'd2: begin lo = 16; w = 8;  end
            3'd3: begin lo = 24; w = 8;  end
            3'd4: begin lo = 0;  w = 16; end
            3'd5: begin lo = 16; w = 16; end
            default: begin lo = 0; w = 32; end
        endcase
    endfunction

    function automatic logic [31:0] ref_ext(logic [31:0] v, logic [2:0] p, logic sx);
        int lo, w;
        logic [31:0] r;
        field_of(p, lo, w);
        for (int i = 0; i < 32; i++)
            r[i] = (i < w) ? v[lo+i] : (sx ? v[lo+w-1] : 1'b0);
        return r;
    endfunction

    function automatic logic [31:0] ref_merge(logic [31:0] res, logic [31:0] old,
                                              logic [2:0] p, logic [1:0] m);
        int lo, w;
        logic [31:0] r;
        field_of(p, lo, w);
        for (int i = 0; i < 32; i++) begin
            if (i >= lo && i < lo + w) r[i] = res[i-lo];
            else if (m == 2'd0)        r[i] = 1'b0;
            else if (m == 2'd1)        r[i] = (i >= lo + w) ? res[w-1] : 1'b0;
            else                       r[i] = old[i];
        end
        return r;
    endfunction

    function automatic string src_tag(logic [2:0] p, logic sx);
        if (p >= 3'd6) return "R3";
        return sx ? "R2" : "R1";
    endfunction

    // driver: present an item, check operands, queue the merged word
    task automatic drive(logic [31:0] av, logic [31:0] bv, logic [31:0] ov,
                         logic [2:0] ap, logic [2:0] bp, logic asx, logic bsx,
                         logic [2:0] wp, logic [1:0] fm);
        logic [31:0] ea, eb, er, ed;
        @(negedge clk);
        a_in = av; b_in = bv; dest_prev = ov;
        a_pick = ap; b_pick = bp; a_signed = asx; b_signed = bsx;
        wr_pick = wp; fill_mode = fm;
        ea = ref_ext(av, ap, asx);
        eb = ref_ext(bv, bp, bsx);
        er = ea + eb;
        res_in = er;
        in_valid = 1'b1;
        ed = ref_merge(er, ov, wp, fm);
        exp_q.push_back(ed);
        tag_q.push_back(fm == 2'd0 ? "R5/R6" : (fm == 2'd1 ? "R5/R7" : "R5/R8"));
        last_exp = ed;
        #1;
        check(src_tag(ap, asx), a_ext, ea);
        check({"R4 ", src_tag(bp, bsx)}, b_ext, eb);
    endtask

    // monitor: scoreboard comparison of merged words
    always @(negedge clk) begin
        if (rst_n && dest_vld) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 actual=dest_vld expected=no pending item");
            end else begin
                check(tag_q.pop_front(), dest_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 vld", {31'd0, dest_vld}, 32'd0);
        check("R11 dest", dest_out, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // edge patterns forcing sign bits set and clear
        drive(32'h80FF7F80, 32'h7FFF8000, 32'hA5A5A5A5, 3'd0, 3'd5, 1'b1, 1'b1, 3'd2, 2'd1);
        drive(32'h80808080, 32'h80808080, 32'hFFFFFFFF, 3'd7, 3'd6, 1'b1, 1'b1, 3'd0, 2'd0);
        for (int ap = 0; ap < 8; ap++)
            for (int fm = 0; fm < 4; fm++)
                for (int wp = 0; wp < 8; wp++)
                    drive($urandom, $urandom, $urandom, 3'(ap), 3'((ap + wp) % 8),
                          1'(wp), 1'(ap + fm), 3'(wp), 2'(fm));
        @(negedge clk);
        in_valid = 1'b0;
        a_in = $urandom; res_in = $urandom; dest_prev = $urandom;
        repeat (3) @(negedge clk);
        check("R9 idle vld", {31'd0, dest_vld}, 32'd0);
        check("R10 hold", dest_out, last_exp);
        check("R9 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule